// File: doc/BRIEF.md
# Performance Monitor with Split Control, Enable, Status and Select Registers

This block counts hardware activity for profiling. It holds a 32-bit clock-cycle counter and four 32-bit event counters. Each event counter watches one line of an event-pulse vector, chosen by an 8-bit code. The control settings, the per-counter interrupt enables, the per-counter overflow flags and the four event codes each sit in their own register. One register port, with writes and combinational reads, reaches every register and every counter.

Software picks the event codes, loads or clears the counters, sets the global enable, and later reads the counts back. A counter that wraps past all ones sets its overflow flag. A flag whose enable bit is set drives the single interrupt line. Software clears a flag by writing a one to it. A divide mode slows the cycle counter to one step per 64 enabled clocks, so long intervals can be measured.

Top module: `perfmon_unit`

## Requirements
- R1: After reset every counter, the overflow flags and the interrupt enables read 0, and the event select register reads 0xFFFFFFFF. The control register reads with bits 31:24 equal to the parameter ID_BYTE (default 0x52) and all other bits 0. `irq` is low.
- R2: A control write stores only bit 0 (global enable) and bit 3 (cycle divide). A control read returns bit 0, bit 3 and ID_BYTE in bits 31:24, with every other bit read as 0.
- R3: While control bit 0 is 0, no counter advances on any event or clock. The enable, flag and select registers stay readable and writable.
- R4: Writing a 1 to control bit 1 zeroes all four event counters at that write's clock edge. Writing a 1 to control bit 2 zeroes the cycle counter and the divider at that edge. Neither bit affects the other counter group, and neither bit is retained.
- R5: With bit 3 at 0, the cycle counter advances once per enabled clock. With bit 3 at 1, it advances once every 64 enabled clocks, on the 64th, counting from its reset by bit 2.
- R6: The select register holds the code for event counter i in bits 8i+7:8i. Counter i advances on each enabled clock in which `evt_pulse[code]` is 1. A code of 0xFF, or any code of NUM_CODES or above, never counts.
- R7: Register addresses are 0 control, 1 interrupt enable, 2 overflow flags, 3 event select, 4 cycle counter, and 5 to 8 event counters 0 to 3. Counters take written values. A counter stepping from 0xFFFFFFFF wraps to 0 and sets its flag: bit 0 for the cycle counter, bit i+1 for event counter i.
- R8: Writing a 1 to an overflow flag bit clears that flag, and writing 0 leaves it unchanged. The flag register reads as 5 bits with the upper bits 0.
- R9: The interrupt enable register uses the same five-bit layout as the flags and reads its upper bits as 0. `irq` is 1 exactly when some flag and its enable bit are both 1.
- R10: If a counter wraps in the same cycle that software writes a 1 to clear its flag, the flag stays set.
- R11: A register write to a counter in a cycle where that counter would also advance loads the written value, and the increment is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_pulse | input | NUM_CODES | Event pulses, one line per event code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt: any enabled overflow flag set |

## Verification
Two functions can land in the same clock: a counter wrapping and a software write of one that clears its overflow flag. The bench sets the flag first. It then preloads the cycle counter with all ones and issues back-to-back writes, so that the flag-clear write lands on exactly the edge where the counter wraps. The flag must read 1 afterwards, and a later clear with no wrap must take it to 0. A similar back-to-back pair checks that a counter load wins over a concurrent increment.

// File: rtl/perfmon_pkg.sv
package perfmon_pkg;
  localparam int DATA_W   = 32;
  localparam int CODE_W   = 8;
  localparam int NUM_EVT  = DATA_W / CODE_W;
  localparam int NUM_FLAG = NUM_EVT + 1;
  localparam int ADDR_W   = 4;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd1;
  localparam logic [ADDR_W-1:0] A_OVF  = 4'd2;
  localparam logic [ADDR_W-1:0] A_ESEL = 4'd3;
  localparam logic [ADDR_W-1:0] A_CYC  = 4'd4;
  localparam logic [ADDR_W-1:0] A_EVT0 = 4'd5;

  localparam logic [CODE_W-1:0] CODE_OFF = 8'hFF;

  // Control read view: ID byte on top, enable and divide bits, others zero.
  function automatic logic [DATA_W-1:0] ctrl_view(input logic en, input logic div,
                                                  input logic [7:0] id);
    return {id, 20'b0, div, 2'b00, en};
  endfunction

  // Code field belonging to event counter idx.
  function automatic logic [CODE_W-1:0] sel_code(input logic [DATA_W-1:0] sel, input int idx);
    return sel[CODE_W*idx +: CODE_W];
  endfunction

  // Zero-extend a flag-wide vector onto the data bus.
  function automatic logic [DATA_W-1:0] flag_view(input logic [NUM_FLAG-1:0] f);
    return {{(DATA_W-NUM_FLAG){1'b0}}, f};
  endfunction
endpackage

// File: rtl/perfmon_ctrl.sv
module perfmon_ctrl
  import perfmon_pkg::*;
#(
  parameter int NUM_CODES = 32,
  parameter int PRE_DIV   = 64
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_ctrl,
  input  logic                 wr_ien,
  input  logic                 wr_esel,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [NUM_CODES-1:0] evt_pulse,
  output logic                 en_q,
  output logic                 div_q,
  output logic [NUM_FLAG-1:0]  ien_q,
  output logic [DATA_W-1:0]    esel_q,
  output logic                 cyc_inc,
  output logic [NUM_EVT-1:0]   evt_inc,
  output logic                 cyc_clr,
  output logic                 evt_clr
);
  localparam int PW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(PRE_DIV - 1);

  logic [PW-1:0] pre_q;
  logic          pre_wrap;

  assign cyc_clr  = wr_ctrl & wdata[2];
  assign evt_clr  = wr_ctrl & wdata[1];
  assign pre_wrap = (pre_q == PRE_LAST);
  assign cyc_inc  = en_q & (~div_q | pre_wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      div_q  <= 1'b0;
      ien_q  <= '0;
      esel_q <= '1;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata[0];
        div_q <= wdata[3];
      end
      if (wr_ien)  ien_q  <= wdata[NUM_FLAG-1:0];
      if (wr_esel) esel_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pre_q <= '0;
    else if (cyc_clr)  pre_q <= '0;
    else if (en_q)     pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
  end

  always_comb begin
    for (int i = 0; i < NUM_EVT; i++) begin
      logic hit;
      hit = 1'b0;
      for (int k = 0; k < NUM_CODES; k++)
        if (sel_code(esel_q, i) == CODE_W'(k)) hit = hit | evt_pulse[k];
      evt_inc[i] = en_q & hit;
    end
  end

  // R5: in divide mode two cycle steps are never adjacent
  a_r5_divided_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && div_q && cyc_inc && !wr_ctrl) |=> !cyc_inc);
  // R3: with the enable off the divider holds
  a_r3_divider_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_ctrl) |=> $stable(pre_q));
endmodule

// File: rtl/perfmon_counter.sv
module perfmon_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         clr,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] value,
  output logic         wrap
);
  assign wrap = inc & ~wr & ~clr & (&value);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   value <= '0;
    else if (wr)  value <= wdata;
    else if (clr) value <= '0;
    else if (inc) value <= value + 1'b1;
  end

  // R7: a wrap lands on zero
  a_r7_wrap_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (value == '0));
  // R11: a load beats a concurrent step
  a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (value == $past(wdata)));
  // R4: a clear without load gives zero
  a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !wr) |=> (value == '0));
endmodule

// File: rtl/perfmon_ovf.sv
module perfmon_ovf #(
  parameter int N = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wrap,
  input  logic         clr_wr,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] ien,
  output logic [N-1:0] flags,
  output logic         irq
);
  logic [N-1:0] clr_eff;

  assign clr_eff = clr_wr ? clr_mask : '0;
  assign irq     = |(flags & ien);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else        flags <= (flags & ~clr_eff) | wrap;
  end

  // R10: a wrap always leaves its flag set, clear or not
  a_r10_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (|wrap) |=> ((flags & $past(wrap)) == $past(wrap)));
  // R8: write-one clears when no wrap coincides
  a_r8_one_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !(|wrap)) |=> ((flags & $past(clr_mask)) == '0));
  // R8: with no clear and no wrap flags hold
  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_wr && !(|wrap)) |=> $stable(flags));
endmodule

// File: rtl/perfmon_unit.sv
module perfmon_unit
  import perfmon_pkg::*;
#(
  parameter int         NUM_CODES = 32,
  parameter int         PRE_DIV   = 64,
  parameter logic [7:0] ID_BYTE   = 8'h52
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_CODES-1:0] evt_pulse,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq
);
  logic                en_w, div_w;
  logic [NUM_FLAG-1:0] ien_w, flags_w, wrap_w;
  logic [DATA_W-1:0]   esel_w;
  logic                cyc_inc_w, cyc_clr_w, evt_clr_w;
  logic [NUM_EVT-1:0]  evt_inc_w;
  logic [DATA_W-1:0]   cyc_val;
  logic [DATA_W-1:0]   evt_val [NUM_EVT];

  logic wr_ctrl, wr_ien, wr_ovf, wr_esel, wr_cyc;
  assign wr_ctrl = reg_wr && (reg_addr == A_CTRL);
  assign wr_ien  = reg_wr && (reg_addr == A_IEN);
  assign wr_ovf  = reg_wr && (reg_addr == A_OVF);
  assign wr_esel = reg_wr && (reg_addr == A_ESEL);
  assign wr_cyc  = reg_wr && (reg_addr == A_CYC);

  perfmon_ctrl #(.NUM_CODES(NUM_CODES), .PRE_DIV(PRE_DIV)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .wr_ctrl(wr_ctrl), .wr_ien(wr_ien), .wr_esel(wr_esel),
    .wdata(reg_wdata), .evt_pulse(evt_pulse),
    .en_q(en_w), .div_q(div_w), .ien_q(ien_w), .esel_q(esel_w),
    .cyc_inc(cyc_inc_w), .evt_inc(evt_inc_w),
    .cyc_clr(cyc_clr_w), .evt_clr(evt_clr_w)
  );

  perfmon_counter #(.W(DATA_W)) u_cyc (
    .clk(clk), .rst_n(rst_n), .inc(cyc_inc_w), .clr(cyc_clr_w),
    .wr(wr_cyc), .wdata(reg_wdata), .value(cyc_val), .wrap(wrap_w[0])
  );

  for (genvar i = 0; i < NUM_EVT; i++) begin : g_evt
    logic wr_this;
    assign wr_this = reg_wr && (reg_addr == A_EVT0 + ADDR_W'(i));
    perfmon_counter #(.W(DATA_W)) u_evt (
      .clk(clk), .rst_n(rst_n), .inc(evt_inc_w[i]), .clr(evt_clr_w),
      .wr(wr_this), .wdata(reg_wdata), .value(evt_val[i]), .wrap(wrap_w[i+1])
    );
  end

  perfmon_ovf #(.N(NUM_FLAG)) u_ovf (
    .clk(clk), .rst_n(rst_n), .wrap(wrap_w), .clr_wr(wr_ovf),
    .clr_mask(reg_wdata[NUM_FLAG-1:0]), .ien(ien_w),
    .flags(flags_w), .irq(irq)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:  reg_rdata = ctrl_view(en_w, div_w, ID_BYTE);
      A_IEN:   reg_rdata = flag_view(ien_w);
      A_OVF:   reg_rdata = flag_view(flags_w);
      A_ESEL:  reg_rdata = esel_w;
      A_CYC:   reg_rdata = cyc_val;
      default: reg_rdata = '0;
    endcase
    for (int i = 0; i < NUM_EVT; i++)
      if (reg_addr == A_EVT0 + ADDR_W'(i)) reg_rdata = evt_val[i];
  end

  // R3: with the enable off and no write, no counter moves
  a_r3_frozen_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_w && !reg_wr) |=> $stable(cyc_val));
  a_r3_frozen_evt0: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_w && !reg_wr) |=> $stable(evt_val[0]));
  // R9: a freshly set flag under a set enable raises irq
  a_r9_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
    ((|wrap_w) && ((wrap_w & ien_w) != '0) && !wr_ien) |=> irq);
endmodule

// File: tb/perfmon_unit_bench.sv
module perfmon_unit_bench;
  localparam int NC = 32;
  localparam logic [3:0] AC = 4'd0, AI = 4'd1, AO = 4'd2, AS = 4'd3, AY = 4'd4, AE = 4'd5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NC-1:0] evt_pulse = '0;
  logic        reg_wr = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  perfmon_unit u_perfmon_unit (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_count(input logic [7:0] code);
    return (code < NC) ? 32'(NC - code) : 32'd0;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, c0;
    logic [31:0] cfgs [4];
    cfgs[0] = 32'h03020100; cfgs[1] = 32'h1F1E0F10;
    cfgs[2] = 32'hFF20FF1F; cfgs[3] = 32'h00FF8001;

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1 reset state
    rd(AC, v); chk("R1 ctrl", v, 32'h52000000);
    rd(AI, v); chk("R1 ien", v, 0);
    rd(AO, v); chk("R1 ovf", v, 0);
    rd(AS, v); chk("R1 esel", v, 32'hFFFFFFFF);
    rd(AY, v); chk("R1 cycle", v, 0);
    for (int i = 0; i < 4; i++) begin rd(AE + 4'(i), v); chk("R1 evt", v, 0); end
    chk("R1 irq", 32'(irq), 0);

    // R2 write and read masking
    wr(AC, 32'h5A5A5A59); rd(AC, v); chk("R2 ctrl mask", v, 32'h52000009);
    wr(AC, 32'hFFFFFFF6); rd(AC, v); chk("R2 ctrl low", v, 32'h52000000);

    // R5 plain and divided cycle counting
    wr(AC, 32'h5); idle(10); rd(AY, v); chk("R5 plain", v, 10);
    wr(AC, 32'hD); idle(63); rd(AY, v); chk("R5 div 63", v, 0);
    idle(1); rd(AY, v); chk("R5 div 64", v, 1);
    idle(129); wr(AC, 32'h0); rd(AY, v); chk("R5 div 194", v, 3);

    // R3 disabled: nothing counts, registers still work
    wr(AS, 32'h0); evt_pulse = '1; idle(20); evt_pulse = '0;
    rd(AY, v); chk("R3 cycle held", v, 3);
    rd(AE, v); chk("R3 evt held", v, 0);
    wr(AI, 32'hFFFFFFFF); rd(AI, v); chk("R9 ien mask", v, 32'h1F);
    wr(AI, 32'h0);

    // R6 sweep over select configurations
    foreach (cfgs[c]) begin
      wr(AC, 32'h6); wr(AS, cfgs[c]);
      rd(AS, v); chk("R6 esel readback", v, cfgs[c]);
      wr(AC, 32'h1);
      for (int s = 1; s <= NC; s++) begin
        logic [NC:0] m;
        m = (33'd1 << s) - 33'd1;
        evt_pulse = m[NC-1:0];
        @(posedge clk); @(negedge clk);
      end
      evt_pulse = '0;
      wr(AC, 32'h0);
      for (int i = 0; i < 4; i++) begin
        rd(AE + 4'(i), v);
        chk("R6 evt count", v, exp_count(cfgs[c][8*i +: 8]));
      end
    end

    // R4 group resets
    rd(AY, c0);
    wr(AC, 32'h2);
    for (int i = 0; i < 4; i++) begin rd(AE + 4'(i), v); chk("R4 evt clear", v, 0); end
    rd(AY, v); chk("R4 cycle untouched", v, c0);
    wr(AC, 32'h4); rd(AY, v); chk("R4 cycle clear", v, 0);
    rd(AC, v); chk("R4 not retained", v, 32'h52000000);

    // R7 wrap of the cycle counter and an event counter
    wr(AY, 32'hFFFFFFFF); wr(AC, 32'h1); wr(AC, 32'h0);
    rd(AY, v); chk("R7 cycle wrap", v, 0);
    rd(AO, v); chk("R7 cycle flag", v, 32'h1);
    chk("R9 irq masked", 32'(irq), 0);
    wr(AI, 32'h1); chk("R9 irq on", 32'(irq), 1);
    wr(AE + 4'd2, 32'hFFFFFFFF); wr(AS, 32'hFF05FFFF); wr(AC, 32'h1);
    evt_pulse = 32'h20; @(posedge clk); @(negedge clk); evt_pulse = '0;
    wr(AC, 32'h0);
    rd(AE + 4'd2, v); chk("R7 evt2 wrap", v, 0);
    rd(AO, v); chk("R7 evt2 flag", v, 32'h9);

    // R8 write-one-to-clear
    wr(AO, 32'h8); rd(AO, v); chk("R8 clear bit3", v, 32'h1);
    wr(AO, 32'h0); rd(AO, v); chk("R8 zero write", v, 32'h1);
    chk("R9 irq held", 32'(irq), 1);
    wr(AI, 32'h8); chk("R9 irq off", 32'(irq), 0);
    wr(AO, 32'hFFFFFFE1); rd(AO, v); chk("R8 clear bit0", v, 0);

    // R10 wrap coinciding with a clear
    wr(AY, 32'hFFFFFFFF); wr(AC, 32'h1); wr(AC, 32'h0);
    rd(AO, v); chk("R10 setup", v, 32'h1);
    wr(AY, 32'hFFFFFFFF); wr(AC, 32'h1); wr(AO, 32'h1); wr(AC, 32'h0);
    rd(AO, v); chk("R10 flag kept", v, 32'h1);
    rd(AY, v); chk("R10 cycle", v, 1);
    wr(AO, 32'h1); rd(AO, v); chk("R10 later clear", v, 0);

    // R11 load beats a concurrent increment
    wr(AC, 32'h1); wr(AY, 32'd100); wr(AC, 32'h0);
    rd(AY, v); chk("R11 load wins", v, 101);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule